// File: doc/BRIEF.md
# CPU Address Decode Window Unit

This unit maps each 32-bit CPU address onto an interconnect target. It keeps eight programmable windows. Each window is described by a 64 KB aligned base, a span mask that holds (size − 1) in 64 KB pages, an enable, a 4-bit target port number and an 8-bit attribute byte. Software sets the windows up through a plain 32-bit register write port. The register read data is combinational from the register address.

A request is a valid strobe plus an address. One clock later the unit returns a response. On a hit, the response carries the target and the attribute of the winning window together with the address to forward. The two lowest-numbered windows can also replace the page bits outside their span with a programmable remap value. On a miss, the response raises a miss flag.

The response path is a three-state machine:
- **RSP_IDLE**: no response.
- **RSP_HIT**: a window matched.
- **RSP_MISS**: no window matched.

On every clock the next state is chosen from the current request alone. With no valid request the machine goes to RSP_IDLE. With a valid request and at least one matching window it goes to RSP_HIT. With a valid request and no matching window it goes to RSP_MISS. Each of these three transitions can be taken from any state.

Top module: `addr_win_decoder`

## Requirements
- R1: After reset every register reads zero, every window is disabled, any request is answered as a miss, and rsp_valid is low while reset is held.
- R2: reg_addr[6:4] selects the window and reg_addr[3:2] selects the word in that window's 16-byte group: 0 is control, 1 is base, 2 is remap-low, 3 is remap-high. reg_rdata shows the addressed word in the same cycle.
- R3: The control word holds the span mask in bits 31:16, the attribute in bits 15:8, the enable in bit 5 and the target in bits 3:0. Bits 7:6 and bit 4 read as zero.
- R4: The base register keeps only bits 31:16, and bits 15:0 read zero. On windows 0 and 1, remap-low also keeps only bits 31:16, while remap-high keeps all 32 bits.
- R5: On windows 2 to 7, the remap-low and remap-high offsets read zero and ignore writes.
- R6: A window matches when its enable is set and (addr[31:16] & ~mask) equals (base[31:16] & ~mask).
- R7: When several enabled windows match, the lowest-numbered one supplies target, attribute and address. Target and attribute values pass through unchanged, for example targets 0, 1, 3 and 4 and attributes 0x0F, 0x1B, 0x1D, 0x1E, 0x51 and 0x59.
- R8: On a hit in window 0 or 1, the output upper half is (remap[31:16] & ~mask) | (addr[31:16] & mask).
- R9: On a hit in windows 2 to 7, the output address equals the request address. In every response, bits 15:0 equal the request's bits 15:0.
- R10: With no matching window, rsp_miss is high, target and attribute are zero, and the output address equals the request address.
- R11: rsp_valid is high exactly in the cycle after a cycle with req_valid high. rsp_miss is never high while rsp_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register byte address (window, word) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| req_valid | input | 1 | Decode request strobe |
| req_addr | input | 32 | Address to decode |
| rsp_valid | output | 1 | Response present |
| rsp_miss | output | 1 | No window matched |
| rsp_target | output | 4 | Target port of the winning window |
| rsp_attr | output | 8 | Attribute byte of the winning window |
| rsp_addr | output | 32 | Forwarded (possibly remapped) address |

## Verification
The bench uses the default build: eight windows, of which the first two can remap. Because the match only looks at a 16-bit page number, all 65536 page numbers can be swept on one overlapping window set, with a varying low half. That sweep reaches every priority collision, the edges of every span, disabled windows lying under enabled ones, and both remap windows. A second, narrower sweep runs after the top-priority window has been switched off. It shows that the window below it now wins in the overlapped range.

// File: rtl/addr_win_pkg.sv
package addr_win_pkg;

    localparam int ADDR_W = 32;
    localparam int PAGE_W = 16;
    localparam int TGT_W  = 4;
    localparam int ATTR_W = 8;

    localparam logic [TGT_W-1:0] TGT_DRAM  = 4'd0;
    localparam logic [TGT_W-1:0] TGT_DEVB  = 4'd1;
    localparam logic [TGT_W-1:0] TGT_PEX0  = 4'd3;
    localparam logic [TGT_W-1:0] TGT_PEX1  = 4'd4;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_BASE = 2'd1,
        REG_RLO  = 2'd2,
        REG_RHI  = 2'd3
    } reg_word_e;

    typedef enum logic [1:0] {
        RSP_IDLE = 2'd0,
        RSP_HIT  = 2'd1,
        RSP_MISS = 2'd2
    } rsp_state_e;

    typedef struct packed {
        logic [PAGE_W-1:0] span;
        logic [ATTR_W-1:0] attr;
        logic              en;
        logic [TGT_W-1:0]  tgt;
        logic [PAGE_W-1:0] base;
        logic [PAGE_W-1:0] rlo;
        logic [ADDR_W-1:0] rhi;
    } win_cfg_t;

endpackage

// File: rtl/awd_regbank.sv
module awd_regbank
    import addr_win_pkg::*;
#(
    parameter int NUM_WIN   = 8,
    parameter int NUM_REMAP = 2,
    localparam int WIN_IW   = $clog2(NUM_WIN),
    localparam int REG_AW   = WIN_IW + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_AW-1:0] addr,
    input  logic [ADDR_W-1:0] wdata,
    output logic [ADDR_W-1:0] rdata,
    output win_cfg_t          cfg [NUM_WIN]
);

    logic [WIN_IW-1:0] win_sel;
    reg_word_e         word_sel;

    assign win_sel  = addr[REG_AW-1:4];
    assign word_sel = reg_word_e'(addr[3:2]);

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        logic              wsel;
        logic [PAGE_W-1:0] span_q;
        logic [ATTR_W-1:0] attr_q;
        logic              en_q;
        logic [TGT_W-1:0]  tgt_q;
        logic [PAGE_W-1:0] base_q;
        logic [PAGE_W-1:0] rlo_w;
        logic [ADDR_W-1:0] rhi_w;

        assign wsel = we && (win_sel == WIN_IW'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                span_q <= '0;
                attr_q <= '0;
                en_q   <= 1'b0;
                tgt_q  <= '0;
                base_q <= '0;
            end else if (wsel) begin
                if (word_sel == REG_CTRL) begin
                    span_q <= wdata[31:16];
                    attr_q <= wdata[15:8];
                    en_q   <= wdata[5];
                    tgt_q  <= wdata[3:0];
                end
                if (word_sel == REG_BASE) begin
                    base_q <= wdata[31:16];
                end
            end
        end

        if (i < NUM_REMAP) begin : g_remap
            logic [PAGE_W-1:0] rlo_q;
            logic [ADDR_W-1:0] rhi_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    rlo_q <= '0;
                    rhi_q <= '0;
                end else if (wsel) begin
                    if (word_sel == REG_RLO) rlo_q <= wdata[31:16];
                    if (word_sel == REG_RHI) rhi_q <= wdata;
                end
            end
            assign rlo_w = rlo_q;
            assign rhi_w = rhi_q;
        end else begin : g_noremap
            assign rlo_w = '0;
            assign rhi_w = '0;
        end

        assign cfg[i] = '{span: span_q, attr: attr_q, en: en_q, tgt: tgt_q,
                          base: base_q, rlo: rlo_w, rhi: rhi_w};
    end

    always_comb begin
        win_cfg_t c;
        c     = cfg[win_sel];
        rdata = '0;
        unique case (word_sel)
            REG_CTRL: rdata = {c.span, c.attr, 2'b00, c.en, 1'b0, c.tgt};
            REG_BASE: rdata = {c.base, {PAGE_W{1'b0}}};
            REG_RLO:  rdata = {c.rlo, {PAGE_W{1'b0}}};
            REG_RHI:  rdata = c.rhi;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/awd_win_match.sv
module awd_win_match
    import addr_win_pkg::*;
#(
    parameter bit CAN_REMAP = 1'b0
) (
    input  win_cfg_t          cfg,
    input  logic [PAGE_W-1:0] page,
    output logic              hit,
    output logic [PAGE_W-1:0] xlat_page
);

    assign hit = cfg.en && ((page & ~cfg.span) == (cfg.base & ~cfg.span));

    if (CAN_REMAP) begin : g_xlat
        assign xlat_page = (cfg.rlo & ~cfg.span) | (page & cfg.span);
    end else begin : g_pass
        assign xlat_page = page;
    end

endmodule

// File: rtl/addr_win_decoder.sv
module addr_win_decoder
    import addr_win_pkg::*;
#(
    parameter int NUM_WIN   = 8,
    parameter int NUM_REMAP = 2,
    localparam int WIN_IW   = $clog2(NUM_WIN),
    localparam int REG_AW   = WIN_IW + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic              rsp_miss,
    output logic [TGT_W-1:0]  rsp_target,
    output logic [ATTR_W-1:0] rsp_attr,
    output logic [ADDR_W-1:0] rsp_addr
);

    win_cfg_t          cfg       [NUM_WIN];
    logic [NUM_WIN-1:0] win_hit;
    logic [PAGE_W-1:0] win_page  [NUM_WIN];

    awd_regbank #(.NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .cfg   (cfg)
    );

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_match
        awd_win_match #(.CAN_REMAP(i < NUM_REMAP)) u_m (
            .cfg       (cfg[i]),
            .page      (req_addr[ADDR_W-1:ADDR_W-PAGE_W]),
            .hit       (win_hit[i]),
            .xlat_page (win_page[i])
        );
    end

    // lowest index wins
    logic              any_hit;
    logic [WIN_IW-1:0] sel_idx;
    always_comb begin
        any_hit = 1'b0;
        sel_idx = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (win_hit[i]) begin
                any_hit = 1'b1;
                sel_idx = WIN_IW'(i);
            end
        end
    end

    rsp_state_e        state_q, state_d;
    logic [TGT_W-1:0]  tgt_q;
    logic [ATTR_W-1:0] attr_q;
    logic [ADDR_W-1:0] addr_q;

    always_comb begin
        if (!req_valid)   state_d = RSP_IDLE;
        else if (any_hit) state_d = RSP_HIT;
        else              state_d = RSP_MISS;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RSP_IDLE;
        else        state_q <= state_d;
    end

    // response payload
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_q  <= '0;
            attr_q <= '0;
            addr_q <= '0;
        end else if (req_valid) begin
            tgt_q  <= cfg[sel_idx].tgt;
            attr_q <= cfg[sel_idx].attr;
            addr_q <= any_hit ? {win_page[sel_idx], req_addr[ADDR_W-PAGE_W-1:0]}
                              : req_addr;
        end
    end

    // outputs
    always_comb begin
        rsp_valid  = 1'b0;
        rsp_miss   = 1'b0;
        rsp_target = '0;
        rsp_attr   = '0;
        rsp_addr   = '0;
        unique case (state_q)
            RSP_IDLE: ;
            RSP_HIT: begin
                rsp_valid  = 1'b1;
                rsp_target = tgt_q;
                rsp_attr   = attr_q;
                rsp_addr   = addr_q;
            end
            RSP_MISS: begin
                rsp_valid = 1'b1;
                rsp_miss  = 1'b1;
                rsp_addr  = addr_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/awd_checker.sv
module awd_checker
    import addr_win_pkg::*;
#(
    parameter int NUM_WIN   = 8,
    parameter int NUM_REMAP = 2,
    localparam int WIN_IW   = $clog2(NUM_WIN),
    localparam int REG_AW   = WIN_IW + 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [REG_AW-1:0] reg_addr,
    input logic [ADDR_W-1:0] reg_rdata,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic              rsp_miss,
    input logic [TGT_W-1:0]  rsp_target,
    input logic [ATTR_W-1:0] rsp_attr,
    input logic [ADDR_W-1:0] rsp_addr
);

    // R11
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R11
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R11
    miss_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !rsp_miss);

    // R10
    miss_zero_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_miss) |-> (rsp_target == '0 && rsp_attr == '0));

    // R10
    miss_addr_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!rsp_miss || rsp_addr == $past(req_addr)));

    // R9
    low_half_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_addr[ADDR_W-PAGE_W-1:0] == $past(req_addr[ADDR_W-PAGE_W-1:0])));

    // R5
    remap_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(reg_addr[REG_AW-1:4]) >= NUM_REMAP && reg_addr[3]) |-> reg_rdata == '0);

    // R4
    base_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr[3:2] == 2'd1) |-> reg_rdata[PAGE_W-1:0] == '0);

    // R3
    ctrl_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr[3:2] == 2'd0) |-> (reg_rdata & 32'h0000_00D0) == '0);

endmodule

bind addr_win_decoder awd_checker #(.NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .rsp_valid  (rsp_valid),
    .rsp_miss   (rsp_miss),
    .rsp_target (rsp_target),
    .rsp_attr   (rsp_attr),
    .rsp_addr   (rsp_addr)
);

// File: tb/addr_win_decoder_tb_top.sv
`timescale 1ns/1ps
module addr_win_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [6:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        req_valid;
    logic [31:0] req_addr;
    logic        rsp_valid, rsp_miss;
    logic [3:0]  rsp_target;
    logic [7:0]  rsp_attr;
    logic [31:0] rsp_addr;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    logic [31:0] m_ctrl [8];
    logic [31:0] m_base [8];
    logic [31:0] m_rlo  [8];
    logic [31:0] m_rhi  [8];

    always #4 clk = ~clk;

    addr_win_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_miss(rsp_miss),
        .rsp_target(rsp_target), .rsp_attr(rsp_attr), .rsp_addr(rsp_addr)
    );

    function automatic logic [31:0] mk_ctrl(input logic [15:0] span, input logic [7:0] attr,
                                            input logic en, input logic [3:0] tgt);
        return {span, attr, 2'b00, en, 1'b0, tgt};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int win, input int word, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = 7'((win << 4) | (word << 2)); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        case (word)
            0: m_ctrl[win] = d & 32'hFFFF_FF2F;
            1: m_base[win] = d & 32'hFFFF_0000;
            2: if (win < 2) m_rlo[win] = d & 32'hFFFF_0000;
            default: if (win < 2) m_rhi[win] = d;
        endcase
    endtask

    task automatic rd_chk(input int win, input int word, input logic [31:0] exp, input string tag);
        reg_addr = 7'((win << 4) | (word << 2));
        #1;
        check(reg_rdata === exp, tag, {32'h0, reg_rdata}, {32'h0, exp});
    endtask

    task automatic model(input logic [31:0] a, output logic eh, output logic [3:0] et,
                         output logic [7:0] ea, output logic [31:0] eo, output string tag);
        eh = 1'b0; et = '0; ea = '0; eo = a; tag = "R10";
        for (int i = 7; i >= 0; i--) begin
            logic [15:0] sp;
            sp = m_ctrl[i][31:16];
            if (m_ctrl[i][5] && ((a[31:16] & ~sp) == (m_base[i][31:16] & ~sp))) begin
                eh = 1'b1;
                et = m_ctrl[i][3:0];
                ea = m_ctrl[i][15:8];
                if (i < 2) begin
                    eo = {(m_rlo[i][31:16] & ~sp) | (a[31:16] & sp), a[15:0]};
                    tag = "R6 R7 R8";
                end else begin
                    eo = a;
                    tag = "R6 R7 R9";
                end
            end
        end
    endtask

    task automatic apply(input logic [31:0] a, input string pre);
        logic eh; logic [3:0] et; logic [7:0] ea; logic [31:0] eo; string tag;
        model(a, eh, et, ea, eo, tag);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        check(rsp_valid === 1'b1 && rsp_miss === !eh && rsp_target === et &&
              rsp_attr === ea && rsp_addr === eo,
              {pre, tag, " R11"},
              {rsp_valid, rsp_miss, 2'b0, rsp_target, rsp_attr, 16'h0, rsp_addr},
              {1'b1, !eh, 2'b0, et, ea, 16'h0, eo});
    endtask

    task automatic idle_chk(input string tag);
        req_valid = 1'b0;
        @(negedge clk);
        check(rsp_valid === 1'b0 && rsp_miss === 1'b0, tag,
              {62'h0, rsp_valid, rsp_miss}, 64'h0);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            m_ctrl[i] = '0; m_base[i] = '0; m_rlo[i] = '0; m_rhi[i] = '0;
        end
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        req_valid = 1'b0; req_addr = '0;
        repeat (3) @(negedge clk);
        check(rsp_valid === 1'b0, "R1 R11", {63'h0, rsp_valid}, 64'h0);
        req_valid = 1'b1; req_addr = 32'h1234_5678;
        @(negedge clk);
        check(rsp_valid === 1'b0, "R1", {63'h0, rsp_valid}, 64'h0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // R1: all registers zero, requests miss
        for (int w = 0; w < 8; w++)
            for (int k = 0; k < 4; k++)
                rd_chk(w, k, 32'h0, "R1 R2");
        apply(32'h0000_0000, "R1 ");
        apply(32'h2000_1234, "R1 ");
        apply(32'hFFFF_FFFF, "R1 ");
        idle_chk("R11");

        // R3: reserved control bits dropped
        wr(4, 0, 32'hFFFF_FFFF);
        rd_chk(4, 0, 32'hFFFF_FF2F, "R3");
        // R4: base low half dropped
        wr(0, 1, 32'h2000_ABCD);
        rd_chk(0, 1, 32'h2000_0000, "R4");

        // overlapping window set
        wr(0, 0, mk_ctrl(16'h00FF, 8'h1E, 1'b1, 4'd1));
        wr(0, 2, 32'h0340_FFFF);
        wr(0, 3, 32'h0000_0007);
        wr(1, 0, mk_ctrl(16'h0FFF, 8'h59, 1'b1, 4'd3));
        wr(1, 1, 32'h8000_0000);
        wr(1, 2, 32'hC123_0000);
        wr(1, 3, 32'hDEAD_BEEF);
        wr(2, 0, mk_ctrl(16'h00FF, 8'h51, 1'b1, 4'd4));
        wr(2, 1, 32'h8100_0000);
        wr(3, 0, mk_ctrl(16'h003F, 8'h0F, 1'b1, 4'd0));
        wr(3, 1, 32'h2080_0000);
        wr(4, 0, mk_ctrl(16'h0FFF, 8'h0F, 1'b0, 4'd1));
        wr(4, 1, 32'h4000_0000);
        wr(5, 0, mk_ctrl(16'h0000, 8'h1B, 1'b1, 4'd1));
        wr(5, 1, 32'hF000_0000);
        wr(6, 0, mk_ctrl(16'h000F, 8'h1D, 1'b1, 4'd1));
        wr(6, 1, 32'h4010_0000);
        wr(7, 0, mk_ctrl(16'h0FFF, 8'h0F, 1'b1, 4'd0));
        wr(7, 1, 32'h0000_0000);
        // R5: remap writes on windows without remap
        for (int w = 2; w < 8; w++) begin
            wr(w, 2, 32'hFFFF_0000 ^ 32'(w));
            wr(w, 3, 32'hA5A5_5A5A);
        end

        for (int w = 0; w < 8; w++) begin
            rd_chk(w, 0, m_ctrl[w], "R2 R3");
            rd_chk(w, 1, m_base[w], "R2 R4");
            rd_chk(w, 2, m_rlo[w], (w < 2) ? "R2 R4" : "R5");
            rd_chk(w, 3, m_rhi[w], (w < 2) ? "R2 R4" : "R5");
        end

        // full page sweep (R6..R10)
        for (int h = 0; h < 65536; h++) begin
            logic [15:0] lo;
            lo = 16'(h * 40503) ^ 16'h5A5A;
            apply({16'(h), lo}, "");
        end
        idle_chk("R11");

        // gap pattern
        apply(32'h8123_4567, "");
        idle_chk("R11");
        apply(32'h2085_0001, "");
        apply(32'h9999_9999, "");
        idle_chk("R11");

        // R7: switching off window 0 exposes window 3
        wr(0, 0, mk_ctrl(16'h00FF, 8'h1E, 1'b0, 4'd1));
        for (int h = 16'h1F00; h < 16'h2200; h++)
            apply({16'(h), 16'hBEEF}, "");
        idle_chk("R11");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule